// File: doc/BRIEF.md
# Hardware Handshake Flow Controller with Threshold Hysteresis

This block manages the two handshake lines of a serial port. On the receive side it watches the fill count of the local receive FIFO. It drives the active-low request-to-send line from that count. When the count climbs to an upper mark, it releases the line (drives it high). It asserts the line again (drives it low) only after the count falls to a lower mark. Between the two marks the line keeps its last level. A separate trigger level, independent of both marks, raises a receive-data-ready interrupt.

On the transmit side, the active-low clear-to-send input comes from the remote end and passes through a synchronizer. The block uses it to grant the local transmitter permission to start a character. The transmitter holds `tx_boundary` high while it sits between characters. It loads a new character only in a cycle where both `tx_boundary` and `tx_permit` are high. This works like a valid/ready pair at character granularity: the transmitter offers a start, and the permit accepts or stalls it. A character already in progress always completes, because the permit is only re-evaluated while the transmitter sits at a boundary.

Top module: `hwflow_ctl`

## Requirements
- R1: During reset and on release of reset, `rts_n` is 0, `rx_irq` is 0, and `tx_permit` is 0 while auto-CTS is enabled and `tx_boundary` is low.
- R2: `rx_irq` is 1 in the cycle after a clock edge at which `rx_count >= rx_trig`, and 0 in the cycle after an edge where it was below.
- R3: With auto-RTS enabled, `rts_n` becomes 1 one cycle after an edge at which `rx_count >= rts_hi`.
- R4: With auto-RTS enabled, `rts_n` becomes 0 one cycle after an edge at which `rx_count <= rts_lo` and `rx_count < rts_hi`.
- R5: With auto-RTS enabled and `rts_lo < rx_count < rts_hi`, `rts_n` keeps its previous value.
- R6: When `rts_lo >= rts_hi`, the lower mark is taken equal to `rts_hi`. The result is a single threshold: released at `rx_count >= rts_hi`, asserted below it.
- R7: With auto-RTS disabled, `rts_n` equals the inverse of `rts_sw_req` one cycle later.
- R8: A low level on `cts_n` reaches `tx_permit` (with `tx_boundary` high) after exactly two clock edges. After one edge it has not yet reached `tx_permit`.
- R9: While `tx_boundary` is low, `tx_permit` holds the value it had in the previous cycle, whatever `cts_n` does. While `tx_boundary` is high, `tx_permit` shows the current synchronized CTS state.
- R10: With auto-CTS disabled, `tx_permit` is 1.
- R11: Consider two instances in loopback, with the RTS of one driving the CTS of the other, and characters lasting at least 4 clocks. The receiving FIFO count never exceeds `rts_hi + 1`, so it never overflows a FIFO deeper than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_count | input | CNT_W | Current receive FIFO fill count |
| rts_hi | input | CNT_W | Upper mark: release RTS at or above |
| rts_lo | input | CNT_W | Lower mark: assert RTS at or below |
| rx_trig | input | CNT_W | Receive interrupt trigger level |
| auto_rts_en | input | 1 | 1 = RTS driven from fill level |
| auto_cts_en | input | 1 | 1 = transmit gated by CTS |
| rts_sw_req | input | 1 | Software RTS request when auto-RTS is off (1 = assert) |
| cts_n | input | 1 | Asynchronous active-low clear-to-send from the remote side |
| tx_boundary | input | 1 | Transmitter is between characters |
| rts_n | output | 1 | Active-low request-to-send |
| tx_permit | output | 1 | Transmitter may start a character |
| rx_irq | output | 1 | Receive-data-ready interrupt |

## Verification
The interrupt trigger and the upper RTS mark are independent comparisons on the same count. A single step of `rx_count` can therefore cross both in one edge. The bench sets the trigger at, below and above the upper mark in directed ramps and in random trials, and requires `rx_irq` and `rts_n` to each follow their own rule in that same cycle. On the transmit side, a CTS change can arrive in the same cycle as a character start. The bench flips `cts_n` while `tx_boundary` is low and expects no change in `tx_permit` until the boundary returns. The loopback run then checks that these two paths together bound the remote FIFO overshoot to one character.

// File: rtl/hwflow_pkg.sv
package hwflow_pkg;
  // Level of an active-low handshake line.
  typedef enum logic {
    LINE_ASSERTED = 1'b0,
    LINE_RELEASED = 1'b1
  } line_lvl_e;

  localparam int unsigned HWF_SYNC_STAGES = 2;
endpackage

// File: rtl/hwflow_sync.sv
module hwflow_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hwflow_rts.sv
module hwflow_rts
  import hwflow_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic             sw_req,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] mark_hi,
  input  logic [CNT_W-1:0] mark_lo,
  output logic             rts_n
);
  line_lvl_e        rts_q;
  logic [CNT_W-1:0] lo_eff;

  // A lower mark not below the upper one collapses onto it.
  assign lo_eff = (mark_lo < mark_hi) ? mark_lo : mark_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rts_q <= LINE_ASSERTED;
    end else if (!auto_en) begin
      rts_q <= sw_req ? LINE_ASSERTED : LINE_RELEASED;
    end else if (count >= mark_hi) begin
      rts_q <= LINE_RELEASED;
    end else if (count <= lo_eff) begin
      rts_q <= LINE_ASSERTED;
    end
  end

  assign rts_n = rts_q;
endmodule

// File: rtl/hwflow_txgate.sv
module hwflow_txgate (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic cts_ok,
  input  logic tx_boundary,
  output logic tx_permit
);
  logic permit_q;
  logic permit_now;

  // Fresh decision at a boundary, frozen decision mid-character.
  assign permit_now = tx_boundary ? cts_ok : permit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) permit_q <= 1'b0;
    else        permit_q <= permit_now;
  end

  assign tx_permit = !auto_en || permit_now;
endmodule

// File: rtl/hwflow_ctl.sv
module hwflow_ctl
  import hwflow_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rts_hi,
  input  logic [CNT_W-1:0] rts_lo,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             auto_rts_en,
  input  logic             auto_cts_en,
  input  logic             rts_sw_req,
  input  logic             cts_n,
  input  logic             tx_boundary,
  output logic             rts_n,
  output logic             tx_permit,
  output logic             rx_irq
);
  logic cts_n_s;
  logic cts_ok;
  logic irq_q;

  hwflow_sync #(
    .STAGES (HWF_SYNC_STAGES),
    .RST_VAL(LINE_RELEASED)
  ) u_cts_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (cts_n),
    .q    (cts_n_s)
  );

  assign cts_ok = (cts_n_s == LINE_ASSERTED);

  hwflow_rts #(
    .CNT_W(CNT_W)
  ) u_rts (
    .clk    (clk),
    .rst_n  (rst_n),
    .auto_en(auto_rts_en),
    .sw_req (rts_sw_req),
    .count  (rx_count),
    .mark_hi(rts_hi),
    .mark_lo(rts_lo),
    .rts_n  (rts_n)
  );

  hwflow_txgate u_txgate (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_en    (auto_cts_en),
    .cts_ok     (cts_ok),
    .tx_boundary(tx_boundary),
    .tx_permit  (tx_permit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= (rx_count >= rx_trig);
  end

  assign rx_irq = irq_q;
endmodule

// File: rtl/hwflow_ctl_chk.sv
module hwflow_ctl_chk #(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] rts_hi,
  input logic [CNT_W-1:0] rts_lo,
  input logic [CNT_W-1:0] rx_trig,
  input logic             auto_rts_en,
  input logic             auto_cts_en,
  input logic             rts_sw_req,
  input logic             tx_boundary,
  input logic             rts_n,
  input logic             tx_permit,
  input logic             rx_irq
);
  logic [CNT_W-1:0] lo_ref;
  assign lo_ref = (rts_lo < rts_hi) ? rts_lo : rts_hi;

  p_irq_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count >= rx_trig) |=> rx_irq);
  p_irq_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count < rx_trig) |=> !rx_irq);

  p_rts_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_count >= rts_hi) |=> rts_n);

  p_rts_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_count <= lo_ref && rx_count < rts_hi) |=> !rts_n);

  p_rts_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_count > lo_ref && rx_count < rts_hi) |=> (rts_n == $past(rts_n)));

  p_rts_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rts_lo >= rts_hi && rx_count < rts_hi) |=> !rts_n);

  p_rts_sw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |=> (rts_n == !$past(rts_sw_req)));

  p_permit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts_en && $past(auto_cts_en) && !tx_boundary) |-> (tx_permit == $past(tx_permit)));

  p_permit_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_cts_en |-> tx_permit);
endmodule

bind hwflow_ctl hwflow_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_count   (rx_count),
  .rts_hi     (rts_hi),
  .rts_lo     (rts_lo),
  .rx_trig    (rx_trig),
  .auto_rts_en(auto_rts_en),
  .auto_cts_en(auto_cts_en),
  .rts_sw_req (rts_sw_req),
  .tx_boundary(tx_boundary),
  .rts_n      (rts_n),
  .tx_permit  (tx_permit),
  .rx_irq     (rx_irq)
);

// File: tb/hwflow_ctl_tb.sv
`timescale 1ns/1ps
module hwflow_ctl_tb;
  localparam int W     = 7;
  localparam int DEPTH = 16;
  localparam int CHAR  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] cnt = '0, hi = 12, lo = 4, trig = 8;
  logic arts = 1'b1, acts = 1'b1, swr = 1'b0, ctsn = 1'b1, bnd = 1'b0;
  logic rts_n, permit, irq;

  logic         lb_on = 1'b0;
  logic [W-1:0] lb_cnt;
  logic [W-1:0] dut_cnt;
  logic         p_busy;
  logic [3:0]   p_left;
  logic         p_permit, p_rts_n, p_irq;
  int unsigned  pop_div = 16;
  int unsigned  chars = 0, stalls = 0;

  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic exp_rts = 1'b0, exp_irq = 1'b0;

  assign dut_cnt = lb_on ? lb_cnt : cnt;

  hwflow_ctl #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_count(dut_cnt), .rts_hi(hi), .rts_lo(lo),
    .rx_trig(trig), .auto_rts_en(arts), .auto_cts_en(acts), .rts_sw_req(swr),
    .cts_n(ctsn), .tx_boundary(bnd), .rts_n(rts_n), .tx_permit(permit), .rx_irq(irq));

  hwflow_ctl #(.CNT_W(W)) u_peer (
    .clk(clk), .rst_n(rst_n), .rx_count('0), .rts_hi(7'd12), .rts_lo(7'd4),
    .rx_trig(7'd8), .auto_rts_en(1'b0), .auto_cts_en(1'b1), .rts_sw_req(1'b1),
    .cts_n(rts_n), .tx_boundary(!p_busy), .rts_n(p_rts_n), .tx_permit(p_permit),
    .rx_irq(p_irq));

  function automatic logic f_rts(logic prev, logic a, logic s,
                                 logic [W-1:0] c, logic [W-1:0] h, logic [W-1:0] l);
    logic [W-1:0] le;
    if (!a) return !s;
    le = (l < h) ? l : h;
    if (c >= h) return 1'b1;
    if (c <= le) return 1'b0;
    return prev;
  endfunction

  function automatic string f_tag(logic a, logic [W-1:0] c, logic [W-1:0] h, logic [W-1:0] l);
    if (!a) return "R7";
    if (l >= h) return "R6";
    if (c >= h) return "R3";
    if (c <= l) return "R4";
    return "R5";
  endfunction

  task automatic chk(logic act, logic expv, string req);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, expv, $time);
    end
  endtask

  // One clock: model follows the inputs present before the edge.
  task automatic cyc();
    logic a, s; logic [W-1:0] c, h, l, t;
    a = arts; s = swr; c = cnt; h = hi; l = lo; t = trig;
    @(posedge clk); #2;
    exp_rts = f_rts(exp_rts, a, s, c, h, l);
    exp_irq = (c >= t);
  endtask

  task automatic step_chk(logic [W-1:0] c);
    string tg;
    cnt = c;
    tg = f_tag(arts, cnt, hi, lo);
    cyc();
    chk(rts_n, exp_rts, tg);
    chk(irq, exp_irq, "R2");
  endtask

  // Loopback: peer transmitter feeds the FIFO model of u_dut.
  always @(posedge clk) begin
    logic push, pop;
    if (!lb_on) begin
      p_busy <= 1'b0; p_left <= '0; lb_cnt <= '0;
    end else begin
      push = 1'b0;
      if (p_busy) begin
        if (p_left == 0) begin p_busy <= 1'b0; push = 1'b1; end
        else p_left <= p_left - 1'b1;
      end else if (p_permit) begin
        p_busy <= 1'b1; p_left <= 4'(CHAR - 1);
      end else begin
        stalls++;
      end
      pop = (lb_cnt != 0) && ($urandom % pop_div == 0);
      if (push) chars++;
      lb_cnt <= lb_cnt + W'(push) - W'(pop);
    end
  end

  always @(negedge clk) begin
    if (lb_on && !done) begin
      checks++;
      if (lb_cnt > hi + 1 || lb_cnt > DEPTH) begin
        errors++;
        $display("FAIL R11 actual=%0d expected<=%0d", lb_cnt, hi + 1);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    chk(rts_n, 1'b0, "R1");
    chk(irq, 1'b0, "R1");
    chk(permit, 1'b0, "R1");
    rst_n = 1'b1;
    exp_rts = 1'b0; exp_irq = 1'b0;
    cyc();
    chk(rts_n, 1'b0, "R1");
    chk(irq, 1'b0, "R1");

    // R2..R5: ramp up then down through both marks and the trigger
    for (int i = 0; i <= 14; i++) step_chk(W'(i));
    for (int i = 14; i >= 0; i--) step_chk(W'(i));

    // R6: inverted marks collapse to one threshold
    hi = 8; lo = 10;
    step_chk(9); step_chk(8); step_chk(7); step_chk(9); step_chk(8);

    // R7: software control
    arts = 1'b0;
    swr = 1'b1; step_chk(14);
    swr = 1'b0; step_chk(0);
    swr = 1'b1; step_chk(3);
    arts = 1'b1;

    // Random trials over marks, trigger, count and mode
    for (int k = 0; k < 500; k++) begin
      hi   = W'(1 + $urandom % 15);
      lo   = W'($urandom % 16);
      trig = W'($urandom % 16);
      arts = ($urandom % 4) != 0;
      swr  = $urandom % 2;
      step_chk(W'($urandom % 16));
    end
    arts = 1'b1; hi = 12; lo = 4; trig = 8;

    // R8: synchronizer depth
    acts = 1'b1; bnd = 1'b1; ctsn = 1'b1;
    repeat (3) cyc();
    ctsn = 1'b0;
    cyc(); chk(permit, 1'b0, "R8");
    cyc(); chk(permit, 1'b1, "R8");
    cyc();
    // R9: mid-character hold
    bnd = 1'b0; ctsn = 1'b1;
    for (int k = 0; k < 4; k++) begin cyc(); chk(permit, 1'b1, "R9"); end
    bnd = 1'b1; #1;
    chk(permit, 1'b0, "R9");
    cyc(); chk(permit, 1'b0, "R9");
    // R10: gating off
    acts = 1'b0; #1;
    chk(permit, 1'b1, "R10");
    cyc(); chk(permit, 1'b1, "R10");
    acts = 1'b1;

    // R11: loopback between two instances
    cnt = 0; hi = 12; lo = 4; trig = 8; arts = 1'b1; ctsn = 1'b1;
    cyc();
    lb_on = 1'b1;
    pop_div = 16;
    repeat (4000) @(posedge clk);
    pop_div = 3;
    repeat (2000) @(posedge clk);
    pop_div = 12;
    repeat (2000) @(posedge clk);
    #2;
    lb_on = 1'b0;
    checks++;
    if (chars < 100 || stalls == 0) begin
      errors++;
      $display("FAIL R11 actual=chars %0d stalls %0d expected=flow with stalls", chars, stalls);
    end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule